// File: doc/BRIEF.md
# Counting Semaphore Storage Cell

This block is a single synchronisation cell that holds a counting semaphore shared by several requesters. An access carries a view code alongside the read/write direction, and that code chooses the operation. The two P/V views take a unit on a read and give one back on a write. One of them waits when no unit is free and the other only tries. A raw view reads the count without side effects. A control view reads and writes three flag bits that have the same layout as the flags of a queue-type cell.

A waiting P read on a zero count returns a blocked status and sets the requester's bit in a waiter mask. The next V write releases every waiter at once through a one-cycle wake pulse carrying the mask, then clears the mask. Suspending and resuming the requester is left to the logic around the cell. A parameter turns the cell into a queue-type cell. In that case the P/V views do nothing and the control view reports the queue flag as set.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, no waiter is recorded, the three control flags read 0, and rsp_valid and wake_valid are low.
- R2: A read in view 4 (waiting P) or view 5 (trying P) returns the count held before the access, zero-extended on rsp_data, and lowers the count by one when it was above 0.
- R3: A read in view 4 with a count of 0 returns rsp_blocked=1 with rsp_data 0, leaves the count unchanged, and records req_id in the waiter mask.
- R4: A read in view 5 with a count of 0 returns 0 with rsp_blocked=0 and changes neither the count nor the waiter mask.
- R5: A write in view 4 or view 5 raises the count by one unless it already equals 0xFFFF (all ones at CNT_W=16), where it stays. The write data is ignored and the two views act the same.
- R6: A V write made while waiters are recorded gives wake_valid=1 for one cycle, with wake_mask holding every recorded requester bit, and empties the mask. A V write with no waiters leaves wake_valid low.
- R7: A read in view 0 (raw) returns the count unchanged. A write in view 0 is ignored.
- R8: A read in view 1 (control) returns the empty flag on bit 0, the full flag on bit 1, the trigger flag on bit 16, the queue-mode flag (0 here) on bit 17, and 0 on every other bit. A write in view 1 loads only bits 0, 1 and 16 from the write data.
- R9: With FIFO_MODE=1, P reads return 0 with rsp_blocked=0, V writes change nothing and wake nobody, and the control view reads bit 17 as 1.
- R10: Every read gets a response with rsp_valid high on the cycle after the request. Writes get no response.
- R11: Reads in any other view return 0 and change no state. Writes in any other view are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write (V / flag load), 0 = read |
| req_view | input | 4 | View code selecting the operation |
| req_id | input | ID_W | Index of the requesting thread |
| req_wdata | input | DATA_W | Write data (used by the control view only) |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DATA_W | Read response data |
| rsp_blocked | output | 1 | Read was a waiting P on an empty semaphore |
| wake_valid | output | 1 | One-cycle release of recorded waiters |
| wake_mask | output | NUM_REQ | Requesters released by this pulse |

## Verification
A request is sampled on a rising edge. Its response, its wake pulse and its counter update are all registered on that same edge, so each appears one cycle after the request. A count change becomes visible through the next raw or P read. The bench drives every request on the falling edge and compares all outputs against its behavioural model 1 ns after the following rising edge. Because every cycle is checked, an output that comes a cycle early or late is reported as a mismatch. Saturation is reached by running V writes past the limit and reading the count back afterwards.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;
  // view codes decoded from the access
  localparam logic [3:0] VIEW_RAW      = 4'd0;
  localparam logic [3:0] VIEW_CTRL     = 4'd1;
  localparam logic [3:0] VIEW_ACQ_WAIT = 4'd4;
  localparam logic [3:0] VIEW_ACQ_TRY  = 4'd5;

  // control word bit positions, shared with queue-type cells
  localparam int CTL_EMPTY = 0;
  localparam int CTL_FULL  = 1;
  localparam int CTL_TRIG  = 16;
  localparam int CTL_QMODE = 17;

  typedef struct packed {
    logic trig;
    logic full;
    logic empty;
  } ctl_flags_t;
endpackage

// File: rtl/sem_counter.sv
module sem_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc) begin
      if (count != CNT_MAX) count <= count + 1'b1;
    end else if (dec) begin
      if (count != '0) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/sem_waiters.sv
module sem_waiters #(
  parameter int NUM_REQ = 8,
  parameter int ID_W    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               park_en,
  input  logic [ID_W-1:0]    park_id,
  input  logic               release_en,
  output logic               wake_valid,
  output logic [NUM_REQ-1:0] wake_mask
);
  logic [NUM_REQ-1:0] parked;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                    parked[g] <= 1'b0;
      else if (release_en)                        parked[g] <= 1'b0;
      else if (park_en && park_id == ID_W'(g))    parked[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_valid <= 1'b0;
      wake_mask  <= '0;
    end else begin
      wake_valid <= release_en && (|parked);
      wake_mask  <= release_en ? parked : '0;
    end
  end
endmodule

// File: rtl/sem_ctl_flags.sv
module sem_ctl_flags
  import sem_cell_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output ctl_flags_t        flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (load) begin
      flags.empty <= wdata[CTL_EMPTY];
      flags.full  <= wdata[CTL_FULL];
      flags.trig  <= wdata[CTL_TRIG];
    end
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_cell_pkg::*;
#(
  parameter int NUM_REQ   = 8,
  parameter int CNT_W     = 16,
  parameter int DATA_W    = 64,
  parameter bit FIFO_MODE = 1'b0,
  localparam int ID_W     = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [3:0]         req_view,
  input  logic [ID_W-1:0]    req_id,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_blocked,
  output logic               wake_valid,
  output logic [NUM_REQ-1:0] wake_mask
);
  localparam bit SEM_ON = !FIFO_MODE;

  logic [CNT_W-1:0]  cnt_q;
  ctl_flags_t        flags_q;
  logic              is_rd, is_wr, pv_view, cnt_zero;
  logic              do_inc, do_dec, do_park, do_ctl;
  logic [DATA_W-1:0] rd_mux;

  assign is_rd    = req_valid && !req_write;
  assign is_wr    = req_valid && req_write;
  assign pv_view  = (req_view == VIEW_ACQ_WAIT) || (req_view == VIEW_ACQ_TRY);
  assign cnt_zero = (cnt_q == '0);

  assign do_dec  = SEM_ON && is_rd && pv_view && !cnt_zero;
  assign do_park = SEM_ON && is_rd && (req_view == VIEW_ACQ_WAIT) && cnt_zero;
  assign do_inc  = SEM_ON && is_wr && pv_view;
  assign do_ctl  = is_wr && (req_view == VIEW_CTRL);

  sem_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .inc   (do_inc),
    .dec   (do_dec),
    .count (cnt_q)
  );

  sem_waiters #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_waiters (
    .clk        (clk),
    .rst        (rst),
    .park_en    (do_park),
    .park_id    (req_id),
    .release_en (do_inc),
    .wake_valid (wake_valid),
    .wake_mask  (wake_mask)
  );

  sem_ctl_flags #(.DATA_W(DATA_W)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .load  (do_ctl),
    .wdata (req_wdata),
    .flags (flags_q)
  );

  always_comb begin
    rd_mux = '0;
    case (req_view)
      VIEW_RAW: rd_mux = DATA_W'(cnt_q);
      VIEW_CTRL: begin
        rd_mux[CTL_EMPTY] = flags_q.empty;
        rd_mux[CTL_FULL]  = flags_q.full;
        rd_mux[CTL_TRIG]  = flags_q.trig;
        rd_mux[CTL_QMODE] = FIFO_MODE;
      end
      VIEW_ACQ_WAIT, VIEW_ACQ_TRY: rd_mux = SEM_ON ? DATA_W'(cnt_q) : '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_blocked <= 1'b0;
    end else begin
      rsp_valid   <= is_rd;
      rsp_data    <= is_rd ? rd_mux : '0;
      rsp_blocked <= do_park;
    end
  end
endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk #(
  parameter int NUM_REQ = 8,
  parameter int CNT_W   = 16,
  parameter int DATA_W  = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_data,
  input logic               rsp_blocked,
  input logic               wake_valid,
  input logic [NUM_REQ-1:0] wake_mask,
  input logic [CNT_W-1:0]   count
);
  // R10
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write));

  // R3
  blocked_returns_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_blocked |-> (rsp_valid && rsp_data == '0));

  // R6
  wake_has_waiter_chk: assert property (@(posedge clk) disable iff (rst)
    wake_valid |-> (wake_mask != '0));

  // R6
  wake_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    wake_valid |-> $past(req_valid && req_write));

  // R5
  count_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |->
      (count == $past(count) + 1'b1 || count == $past(count) - 1'b1));

  // R2
  count_drop_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count) - 1'b1 && count != $past(count)) |->
      $past(req_valid && !req_write));
endmodule

bind sem_cell sem_cell_chk #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .rsp_blocked(rsp_blocked),
  .wake_valid (wake_valid),
  .wake_mask  (wake_mask),
  .count      (cnt_q)
);

// File: tb/sem_cell_bench.sv
module sem_cell_bench;
  localparam int NQ = 8;
  localparam int IW = 3;
  localparam int DW = 64;
  localparam int CMAX = 65535;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          req_valid = 0, req_write = 0;
  logic [3:0]    req_view = 0;
  logic [IW-1:0] req_id = 0;
  logic [DW-1:0] req_wdata = 0;
  logic          rsp_valid, rsp_blocked, wake_valid;
  logic [DW-1:0] rsp_data;
  logic [NQ-1:0] wake_mask;

  logic          f_valid = 0, f_write = 0;
  logic [3:0]    f_view = 0;
  logic [DW-1:0] f_wdata = 0;
  logic          f_rsp_valid, f_blocked, f_wake;
  logic [DW-1:0] f_data;
  logic [NQ-1:0] f_mask;

  sem_cell u_sem_cell (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_blocked(rsp_blocked),
    .wake_valid(wake_valid), .wake_mask(wake_mask));

  sem_cell #(.FIFO_MODE(1'b1)) u_sem_cell_fifo (
    .clk(clk), .rst(rst), .req_valid(f_valid), .req_write(f_write),
    .req_view(f_view), .req_id(3'd1), .req_wdata(f_wdata),
    .rsp_valid(f_rsp_valid), .rsp_data(f_data), .rsp_blocked(f_blocked),
    .wake_valid(f_wake), .wake_mask(f_mask));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural model state
  int            m_cnt = 0;
  logic [NQ-1:0] m_wait = '0;
  bit            m_e = 0, m_f = 0, m_t = 0;

  task automatic check(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one request on the main cell, model update, compare every output
  task automatic step(string tag, bit v, bit w, logic [3:0] view, int id, logic [DW-1:0] d);
    logic [DW-1:0] e_data = '0;
    bit e_rv = 0, e_blk = 0, e_wv = 0;
    logic [NQ-1:0] e_mask = '0;
    @(negedge clk);
    req_valid = v; req_write = w; req_view = view; req_id = IW'(id); req_wdata = d;
    if (v && !w) begin
      e_rv = 1;
      case (view)
        4'd0: e_data = DW'(m_cnt);
        4'd1: e_data = DW'({m_t, 14'd0, m_f, m_e});
        4'd4, 4'd5: begin
          e_data = DW'(m_cnt);
          if (m_cnt > 0) m_cnt--;
          else if (view == 4'd4) begin e_blk = 1; m_wait[id] = 1'b1; end
        end
        default: e_data = '0;
      endcase
    end else if (v && w) begin
      if (view == 4'd4 || view == 4'd5) begin
        if (m_cnt < CMAX) m_cnt++;
        if (m_wait != '0) begin e_wv = 1; e_mask = m_wait; end
        m_wait = '0;
      end else if (view == 4'd1) begin
        m_e = d[0]; m_f = d[1]; m_t = d[16];
      end
    end
    @(posedge clk);
    #1;
    check(tag, "rsp_valid", DW'(rsp_valid), DW'(e_rv));
    check(tag, "rsp_data", rsp_data, e_data);
    check(tag, "rsp_blocked", DW'(rsp_blocked), DW'(e_blk));
    check(tag, "wake_valid", DW'(wake_valid), DW'(e_wv));
    check(tag, "wake_mask", DW'(wake_mask), DW'(e_mask));
  endtask

  task automatic fstep(string tag, bit w, logic [3:0] view, logic [DW-1:0] d, logic [DW-1:0] e_data);
    @(negedge clk);
    f_valid = 1; f_write = w; f_view = view; f_wdata = d;
    @(posedge clk);
    #1;
    check(tag, "fifo rsp_valid", DW'(f_rsp_valid), DW'(!w));
    check(tag, "fifo rsp_data", f_data, w ? '0 : e_data);
    check(tag, "fifo rsp_blocked", DW'(f_blocked), '0);
    check(tag, "fifo wake_valid", DW'(f_wake), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "rsp_valid in reset", DW'(rsp_valid), '0);
    check("R1", "wake_valid in reset", DW'(wake_valid), '0);
    @(negedge clk); rst = 0;
    step("R1", 0, 0, 4'd0, 0, '0);
    step("R1", 1, 0, 4'd0, 0, '0);
    step("R1", 1, 0, 4'd1, 0, '0);
    // R4 trying P on empty
    step("R4", 1, 0, 4'd5, 1, '0);
    step("R4", 1, 0, 4'd0, 0, '0);
    // R5 V writes, data ignored, both views
    step("R5", 1, 1, 4'd4, 0, 64'hDEAD_BEEF);
    step("R5", 1, 1, 4'd5, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    step("R5", 1, 1, 4'd4, 0, 64'h1234);
    // R7 raw read / ignored raw write
    step("R7", 1, 0, 4'd0, 0, '0);
    step("R7", 1, 1, 4'd0, 0, 64'hFFFF);
    step("R7", 1, 0, 4'd0, 0, '0);
    // R2 P returns pre-count and decrements
    step("R2", 1, 0, 4'd4, 0, '0);
    step("R2", 1, 0, 4'd4, 0, '0);
    step("R2", 1, 0, 4'd5, 0, '0);
    step("R2", 1, 0, 4'd0, 0, '0);
    // R3 waiting P on empty records requesters
    step("R3", 1, 0, 4'd4, 2, '0);
    step("R3", 1, 0, 4'd4, 5, '0);
    step("R4", 1, 0, 4'd5, 3, '0);
    step("R10", 0, 0, 4'd4, 0, '0);
    // R6 release all, then no wake with no waiters
    step("R6", 1, 1, 4'd5, 0, '0);
    step("R6", 1, 1, 4'd4, 0, '0);
    step("R6", 1, 0, 4'd0, 0, '0);
    // R8 control flags
    step("R8", 1, 1, 4'd1, 0, 64'h0000_0000_0001_0003);
    step("R8", 1, 0, 4'd1, 0, '0);
    step("R8", 1, 1, 4'd1, 0, 64'hFFFF_FFFF_FFFE_FFFE);
    step("R8", 1, 0, 4'd1, 0, '0);
    step("R8", 1, 0, 4'd0, 0, '0);
    // R11 other views
    step("R11", 1, 0, 4'd2, 0, '0);
    step("R11", 1, 1, 4'd3, 0, 64'h55);
    step("R11", 1, 1, 4'd15, 0, 64'h7);
    step("R11", 1, 0, 4'd0, 0, '0);
    // R5 saturation
    for (int i = 0; i < CMAX + 4; i++) step("R5", 1, 1, 4'd5, 0, DW'(i));
    step("R5", 1, 0, 4'd0, 0, '0);
    step("R5", 1, 0, 4'd5, 0, '0);
    step("R5", 1, 0, 4'd0, 0, '0);
    step("R10", 0, 0, 4'd0, 0, '0);
    // R9 queue-mode cell
    fstep("R9", 1, 4'd4, 64'h1, '0);
    fstep("R9", 1, 4'd5, 64'h1, '0);
    fstep("R9", 0, 4'd4, '0, '0);
    fstep("R9", 0, 4'd5, '0, '0);
    fstep("R9", 0, 4'd0, '0, '0);
    fstep("R9", 0, 4'd1, '0, 64'h2_0000);
    @(negedge clk); f_valid = 0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule